// File: doc/BRIEF.md
# Comparator-Gated Timer

This block is a 16-bit up-counter whose advance can be gated by a digital comparator result or by an external gate pin, paired with one 8-bit control/status register. All logic runs on a single system clock. The timer clock, the two comparator results and the gate pin arrive asynchronously. Each is passed through a short synchronizer, and the timer clock is then handled as a sampled level whose edges are detected.

A prescaler divides the timer clock by 1, 2, 4 or 8. The counter steps on each rising edge of the divided clock. When re-timing is enabled, the second comparator's result is captured on the falling edge of the divided clock, half a period away from the edge that counts. A gate change therefore cannot race an increment.

The control register holds two reference-select bits, which are only stored and driven out, the gate-source select and the re-timing enable. It also holds read-only copies of both comparator results, taken from one register stage so that they are read together. The counter is reached through two byte-wide registers. Bus reads are combinational and change no state.

Top module: `cmpGateTimer`

## Requirements
- R1: Address 0 is the control register. Bit 7 and bit 6 read the synchronized results of comparator 1 and comparator 2. Bit 5 and bit 4 are read/write reference selects for comparator 1 and comparator 2, reset to 0, and drive `ref1Sel` and `ref2Sel`. Bits 3:2 always read 0. Bit 1 is the gate source select and resets to 1. Bit 0 is the re-timing enable and resets to 0. After reset, address 0 reads 0x02 while both comparator inputs are 0.
- R2: Writes to bits 7:6 of the control register are ignored. Both mirror bits come from the same register stage, so a simultaneous change of both comparator inputs never reads back with only one bit changed.
- R3: The counter advances only while `tmrOn` is 1. If `gateEn` is 0, the gate is ignored. If `gateEn` is 1, the counter advances only while the selected gate source XOR `gateInv` is 1.
- R4: Gate source select = 1 chooses `gatePin`. Gate source select = 0 chooses comparator 2, either direct or re-timed.
- R5: `preSel` codes 0, 1, 2 and 3 divide the timer clock by 1, 2, 4 and 8. The counter advances on rising edges of the divided clock. The prescaler is cleared while `tmrOn` is 0, so 8 timer clock pulses after enabling give 8, 4, 2 and 1 counts.
- R6: With re-timing enabled (bit 0 = 1), comparator 2 is captured on each falling edge of the divided clock. The captured value is cleared to 0 while `tmrOn` is 0. A rising edge therefore uses the value taken at the preceding falling edge.
- R7: The counter wraps from 0xFFFF to 0x0000, and `tmrOvf` is high for exactly one clock cycle on that wrap.
- R8: Address 1 reads and writes counter bits 7:0, and address 2 reads and writes counter bits 15:8. A bus write takes priority over an increment in the same cycle. Address 3 reads 0.
- R9: Reads have no side effect. Holding any read address leaves the counter and the control register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tmrClk | input | 1 | Asynchronous timer clock |
| cmp1Async | input | 1 | Comparator 1 result, asynchronous |
| cmp2Async | input | 1 | Comparator 2 result, asynchronous |
| gatePin | input | 1 | External gate input, asynchronous |
| tmrOn | input | 1 | Timer enable; 0 also clears the prescaler and the capture register |
| gateEn | input | 1 | Gate enable |
| gateInv | input | 1 | Inverts the selected gate source |
| preSel | input | 2 | Prescaler ratio code |
| busWr | input | 1 | Write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| ref1Sel | output | 1 | Stored reference select, comparator 1 |
| ref2Sel | output | 1 | Stored reference select, comparator 2 |
| tmrOvf | output | 1 | One-cycle wrap pulse |

## Verification
The bench builds the block with its default parameters: a 2-bit prescaler code and two synchronizer stages. This makes all four division ratios observable within a burst of eight timer clock pulses. It also keeps the input-to-gate latency short enough to settle inside a fixed wait. The capture register is cleared while the timer is off, so the one-count loss that re-timing causes at the first rising edge can be predicted exactly for ratios 1 and 2.

// File: rtl/cgtPkg.sv
package cgtPkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LO   = 2'd1;
  localparam logic [1:0] ADDR_HI   = 2'd2;

  typedef struct packed {
    logic              incr;
    logic              wrLo;
    logic              wrHi;
    logic [BYTE_W-1:0] data;
  } cntStrobe_t;
endpackage

// File: rtl/cgtSync.sv
module cgtSync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cgtCtrl.sv
module cgtCtrl
  import cgtPkg::*;
#(
  parameter int PRE_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tmrClkS,
  input  logic                 cmp1S,
  input  logic                 cmp2S,
  input  logic                 gatePinS,
  input  logic                 tmrOn,
  input  logic                 gateEn,
  input  logic                 gateInv,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic                 busWr,
  input  logic [1:0]           busAddr,
  input  logic [BYTE_W-1:0]    busWdata,
  output logic [BYTE_W-1:0]    ctrlRd,
  output cntStrobe_t           cntStb,
  output logic                 ref1Sel,
  output logic                 ref2Sel
);
  localparam int TAPS = 2 ** PRE_SEL_W;
  localparam int PS_W = TAPS - 1;

  logic [1:0]      refSel;
  logic            gateSel, syncEn;
  logic [PS_W-1:0] psCnt;
  logic [TAPS-1:0] psTap;
  logic            tmrPrev, psPrev, psLvl, psRise, psFall, rawRise;
  logic            cmp2Held, gateSrc, gateOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSel  <= 2'b00;
      gateSel <= 1'b1;
      syncEn  <= 1'b0;
    end else if (busWr && busAddr == ADDR_CTRL) begin
      refSel  <= busWdata[5:4];
      gateSel <= busWdata[1];
      syncEn  <= busWdata[0];
    end
  end

  assign rawRise = tmrClkS & ~tmrPrev;
  assign psTap   = {psCnt, tmrClkS};
  assign psLvl   = psTap[preSel];
  assign psRise  = psLvl & ~psPrev;
  assign psFall  = ~psLvl & psPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrPrev  <= 1'b0;
      psPrev   <= 1'b0;
      psCnt    <= '0;
      cmp2Held <= 1'b0;
    end else begin
      tmrPrev <= tmrClkS;
      psPrev  <= psLvl;
      if (!tmrOn)       psCnt <= '0;
      else if (rawRise) psCnt <= psCnt + 1'b1;
      if (!tmrOn)       cmp2Held <= 1'b0;
      else if (psFall)  cmp2Held <= cmp2S;
    end
  end

  assign gateSrc = gateSel ? gatePinS : (syncEn ? cmp2Held : cmp2S);
  assign gateOk  = ~gateEn | (gateSrc ^ gateInv);

  always_comb begin
    cntStb.incr = tmrOn & psRise & gateOk;
    cntStb.wrLo = busWr & (busAddr == ADDR_LO);
    cntStb.wrHi = busWr & (busAddr == ADDR_HI);
    cntStb.data = busWdata;
  end

  assign ctrlRd  = {cmp1S, cmp2S, refSel, 2'b00, gateSel, syncEn};
  assign ref1Sel = refSel[1];
  assign ref2Sel = refSel[0];

  a_r5_ps_cleared: assert property (@(posedge clk) disable iff (!rstN)
    !tmrOn |=> (psCnt == '0));
  a_r6_capture_only_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (tmrOn && !psFall) |=> $stable(cmp2Held));
  a_r6_capture_cleared_off: assert property (@(posedge clk) disable iff (!rstN)
    !tmrOn |=> !cmp2Held);
  a_r1_ctrl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && busAddr == ADDR_CTRL) |=> ($stable(refSel) && $stable(gateSel) && $stable(syncEn)));
endmodule

// File: rtl/cgtCount.sv
module cgtCount
  import cgtPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       cntStb,
  output logic [CNT_W-1:0] count,
  output logic             tmrOvf
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count  <= '0;
      tmrOvf <= 1'b0;
    end else begin
      tmrOvf <= 1'b0;
      if (cntStb.wrLo || cntStb.wrHi) begin
        if (cntStb.wrLo) count[BYTE_W-1:0]     <= cntStb.data;
        if (cntStb.wrHi) count[CNT_W-1:BYTE_W] <= cntStb.data;
      end else if (cntStb.incr) begin
        count  <= count + 1'b1;
        tmrOvf <= (count == '1);
      end
    end
  end

  a_r7_ovf_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |-> (count == '0));
  a_r7_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    tmrOvf |=> !tmrOvf);
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (cntStb.incr && !cntStb.wrLo && !cntStb.wrHi && count != '1) |=> (count == $past(count) + 1'b1));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!cntStb.incr && !cntStb.wrLo && !cntStb.wrHi) |=> $stable(count));
  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    cntStb.wrLo |=> (count[BYTE_W-1:0] == $past(cntStb.data)));
endmodule

// File: rtl/cmpGateTimer.sv
module cmpGateTimer
  import cgtPkg::*;
#(
  parameter int PRE_SEL_W   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tmrClk,
  input  logic                 cmp1Async,
  input  logic                 cmp2Async,
  input  logic                 gatePin,
  input  logic                 tmrOn,
  input  logic                 gateEn,
  input  logic                 gateInv,
  input  logic [PRE_SEL_W-1:0] preSel,
  input  logic                 busWr,
  input  logic [1:0]           busAddr,
  input  logic [7:0]           busWdata,
  output logic [7:0]           busRdata,
  output logic                 ref1Sel,
  output logic                 ref2Sel,
  output logic                 tmrOvf
);
  logic [3:0]        syncIn, syncOut;
  logic [BYTE_W-1:0] ctrlRd;
  logic [CNT_W-1:0]  count;
  cntStrobe_t        cntStb;

  assign syncIn = {tmrClk, cmp1Async, cmp2Async, gatePin};

  cgtSync #(.W(4), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .d(syncIn), .q(syncOut));

  cgtCtrl #(.PRE_SEL_W(PRE_SEL_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .tmrClkS(syncOut[3]), .cmp1S(syncOut[2]), .cmp2S(syncOut[1]), .gatePinS(syncOut[0]),
    .tmrOn(tmrOn), .gateEn(gateEn), .gateInv(gateInv), .preSel(preSel),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .ctrlRd(ctrlRd), .cntStb(cntStb), .ref1Sel(ref1Sel), .ref2Sel(ref2Sel));

  cgtCount uCount (
    .clk(clk), .rstN(rstN), .cntStb(cntStb), .count(count), .tmrOvf(tmrOvf));

  always_comb begin
    unique case (busAddr)
      ADDR_CTRL: busRdata = ctrlRd;
      ADDR_LO:   busRdata = count[BYTE_W-1:0];
      ADDR_HI:   busRdata = count[CNT_W-1:BYTE_W];
      default:   busRdata = '0;
    endcase
  end

  always_comb begin
    if (rstN && busAddr == ADDR_CTRL)
      a_r1_unimpl_zero: assert (busRdata[3:2] == 2'b00);
  end
endmodule

// File: tb/sim_cmpGateTimer.sv
module sim_cmpGateTimer;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       tmrClk = 0, cmp1Async = 0, cmp2Async = 0, gatePin = 0;
  logic       tmrOn = 0, gateEn = 0, gateInv = 0;
  logic [1:0] preSel = 0;
  logic       busWr = 0;
  logic [1:0] busAddr = 0;
  logic [7:0] busWdata = 0;
  logic [7:0] busRdata;
  logic       ref1Sel, ref2Sel, tmrOvf;

  int total = 0, bad = 0, ovfTotal = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmpGateTimer u0 (.*);

  always @(negedge clk) if (tmrOvf) ovfTotal++;

  // {on, gateEn, inv, sel, sync, pre[1:0], cmp2, pin, expected[6:0]}; 8 timer pulses each
  localparam logic [15:0] VEC [14] = '{
    16'b0_1_0_1_0_00_0_1_0000000,
    16'b1_0_0_1_0_00_0_0_0001000,
    16'b1_1_0_1_0_00_0_1_0001000,
    16'b1_1_0_1_0_00_0_0_0000000,
    16'b1_1_0_0_0_00_1_0_0001000,
    16'b1_1_0_0_0_00_0_0_0000000,
    16'b1_1_1_0_0_00_0_0_0001000,
    16'b1_1_1_1_0_00_0_1_0000000,
    16'b1_0_0_1_0_01_0_0_0000100,
    16'b1_0_0_1_0_10_0_0_0000010,
    16'b1_0_0_1_0_11_0_0_0000001,
    16'b1_1_0_0_1_00_1_0_0000111,
    16'b1_1_0_0_1_01_1_0_0000011,
    16'b1_1_1_0_1_00_0_0_0001000
  };

  task automatic check(input int act, input int exp, input string req);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busAddr = a; #1 d = busRdata;
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tmrClk = 1; waitClk(2);
      tmrClk = 0; waitClk(1);
    end
  endtask

  initial begin
    logic [7:0] rd, lo, hi;
    int o0;
    waitClk(3); rstN = 1; waitClk(2);

    // reset state
    busRead(2'd0, rd); check(rd, 8'h02, "R1 reset ctrl");
    check({ref1Sel, ref2Sel}, 0, "R1 ref outputs reset");
    busRead(2'd1, rd); check(rd, 0, "R8 count lo reset");
    check(tmrOvf, 0, "R7 ovf reset");

    // register behaviour
    busWrite(2'd0, 8'hFF); busRead(2'd0, rd);
    check(rd, 8'h33, "R1 write all ones, bits 7:6 and 3:2 read 0");
    check({ref1Sel, ref2Sel}, 2'b11, "R1 ref outputs set");
    busWrite(2'd0, 8'hC0); busRead(2'd0, rd);
    check(rd, 8'h00, "R2 mirror bits ignore write");
    busWrite(2'd0, 8'h20); check({ref1Sel, ref2Sel}, 2'b10, "R1 ref1 only");
    busWrite(2'd0, 8'h02);

    // mirrors change together
    @(negedge clk); cmp1Async = 1; cmp2Async = 1; busAddr = 2'd0;
    for (int i = 0; i < 5; i++) begin
      #1 check(busRdata[7] == busRdata[6], 1, "R2 mirrors not skewed");
      @(negedge clk);
    end
    busRead(2'd0, rd); check(rd[7:6], 2'b11, "R2 both mirrors high");
    @(negedge clk); cmp1Async = 1; cmp2Async = 0; waitClk(4);
    busRead(2'd0, rd); check(rd[7:6], 2'b10, "R2 mirror c1 high c2 low");
    cmp1Async = 0; waitClk(4);

    // byte access
    busWrite(2'd1, 8'h34); busWrite(2'd2, 8'h12);
    busRead(2'd1, lo); busRead(2'd2, hi);
    check({hi, lo}, 16'h1234, "R8 count byte write/read");
    busRead(2'd3, rd); check(rd, 0, "R8 address 3 reads zero");

    // reads have no side effect
    for (int i = 0; i < 6; i++) busRead(2'(i % 3), rd);
    busRead(2'd1, lo); busRead(2'd2, hi);
    check({hi, lo}, 16'h1234, "R9 count unchanged by reads");
    busRead(2'd0, rd); check(rd, 8'h02, "R9 ctrl unchanged by reads");

    // vector table
    for (int v = 0; v < 14; v++) begin
      logic [15:0] e;
      string tag;
      e = VEC[v];
      @(negedge clk); tmrOn = 0; waitClk(3);
      busWrite(2'd0, {6'b0, e[12], e[11]});
      busWrite(2'd1, 0); busWrite(2'd2, 0);
      gateEn = e[14]; gateInv = e[13]; preSel = e[10:9];
      cmp2Async = e[8]; gatePin = e[7];
      waitClk(6); tmrOn = e[15]; waitClk(2);
      tick(8); waitClk(8);
      busRead(2'd1, lo);
      if (e[11])             tag = "R6 retimed gate";
      else if (e[10:9] != 0) tag = "R5 prescale";
      else if (!e[12])       tag = "R4 comparator gate";
      else                   tag = "R3 enable/gate/polarity";
      check(lo, e[6:0], $sformatf("%s vector %0d", tag, v));
    end

    // wrap and overflow pulse
    @(negedge clk); tmrOn = 0; gateEn = 0; preSel = 0; waitClk(3);
    busWrite(2'd1, 8'hFE); busWrite(2'd2, 8'hFF);
    waitClk(2); o0 = ovfTotal; tmrOn = 1; waitClk(2);
    tick(1); waitClk(6);
    busRead(2'd1, lo); busRead(2'd2, hi);
    check({hi, lo}, 16'hFFFF, "R7 reach 0xFFFF");
    check(ovfTotal - o0, 0, "R7 no pulse before wrap");
    tick(1); waitClk(6);
    busRead(2'd1, lo); busRead(2'd2, hi);
    check({hi, lo}, 16'h0000, "R7 wrap to zero");
    check(ovfTotal - o0, 1, "R7 single-cycle pulse");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (R1 to R9 run) actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule